// File: doc/BRIEF.md
# Transmit FIFO Event Status Register

This block keeps the sticky event flags for the transmit side of a serial peripheral controller. It watches the transmit FIFO occupancy count, the push and pop request strobes, and an idle indication from the bit shifter. From these it records seven events: underrun, overflow, full, a completed transfer, and three graded free-space levels (more than a quarter, half or three quarters of the FIFO free). Each flag stays set until software writes a one to its bit at the register offset.

The status word is presented as a 32-bit output. A single interrupt line is the registered OR of the status bits that a mask input enables. The asynchronous active-low reset is synchronized inside the block before it releases the flags. Reset leaves the three free-space flags and the completion flag set.

Top module: `tx_irq_status`

## Requirements
- R1: While reset is asserted, status reads 0x0000_1B00 and irq is 0.
- R2: A pop request while the FIFO level is 0 sets bit 14 (underrun).
- R3: A push request while the level equals DEPTH sets bit 13 (overflow). A push at any lower level does not set it.
- R4: A level equal to DEPTH sets bit 10 (full).
- R5: With free = DEPTH - level, free > DEPTH/4 sets bit 11, free > DEPTH/2 sets bit 9, and free > 3*DEPTH/4 sets bit 12. All three compares are strict, so with DEPTH 64 the levels 48, 32 and 16 do not set their flags.
- R6: Level 0 together with shifter idle sets bit 8 (transfer complete). Level 0 with the shifter busy does not set it.
- R7: Flags are sticky. A write with wr_addr equal to 0x10 clears exactly the bits written as 1. A write to any other address changes nothing.
- R8: When a set condition and a clear hit the same bit in one cycle, the bit ends up set.
- R9: Bits 31:16, bit 15 and bits 7:0 always read 0, whatever is written.
- R10: irq equals the OR of (status AND irq_mask) as it stood one clock earlier.
- R11: A flag changes at the clock edge that samples its condition or its clear write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_level | input | 7 | Transmit FIFO occupancy, 0..DEPTH |
| push_req | input | 1 | Write request into the transmit FIFO |
| pop_req | input | 1 | Read request by the shifter |
| shifter_idle | input | 1 | Shifter has sent its last bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Write data, ones clear flags |
| irq_mask | input | 32 | Per-bit interrupt enable |
| status | output | 32 | Sticky status word |
| irq | output | 1 | Combined masked interrupt |

## Verification
A condition or a clear write applied before clock edge k shows in status right after edge k. The interrupt follows at edge k+1, because it is registered from the status word. The bench drives inputs at the falling edge and steps one full clock. It reads status at the next falling edge, and reads irq one further clock later. Threshold checks hold the level at each boundary and one step inside it. Before every check the bench clears all flags, so that only the live conditions remain.

// File: rtl/txst_pkg.sv
package txst_pkg;

  localparam int unsigned STAT_W   = 32;
  localparam int unsigned BIT_DONE = 8;
  localparam int unsigned BIT_HALF = 9;
  localparam int unsigned BIT_FULL = 10;
  localparam int unsigned BIT_TE14 = 11;
  localparam int unsigned BIT_TE34 = 12;
  localparam int unsigned BIT_OVF  = 13;
  localparam int unsigned BIT_UDR  = 14;

  localparam logic [STAT_W-1:0] STAT_RESET = 32'h0000_1B00;
  localparam logic [STAT_W-1:0] STAT_IMPL  = 32'h0000_7F00;

  typedef struct packed {
    logic udr;
    logic ovf;
    logic te34;
    logic te14;
    logic full;
    logic half;
    logic done;
  } txst_evt_t;

endpackage

// File: rtl/txst_rst_sync.sv
module txst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/txst_cond_decode.sv
module txst_cond_decode
  import txst_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             shifter_idle,
  output txst_evt_t        evt
);

  localparam int unsigned FREE_W = LVL_W + 1;
  localparam logic [FREE_W-1:0] DEPTH_F = FREE_W'(DEPTH);
  localparam logic [FREE_W-1:0] LIM_Q1  = FREE_W'(DEPTH / 4);
  localparam logic [FREE_W-1:0] LIM_Q2  = FREE_W'(DEPTH / 2);
  localparam logic [FREE_W-1:0] LIM_Q3  = FREE_W'((3 * DEPTH) / 4);
  localparam logic [LVL_W-1:0]  LVL_MAX = LVL_W'(DEPTH);

  logic [FREE_W-1:0] free_cnt;
  logic              is_empty;
  logic              is_full;

  always_comb begin
    free_cnt = DEPTH_F - {1'b0, fifo_level};
    is_empty = (fifo_level == '0);
    is_full  = (fifo_level == LVL_MAX);
  end

  always_comb begin
    evt      = '0;
    evt.te14 = (free_cnt > LIM_Q1);
    evt.half = (free_cnt > LIM_Q2);
    evt.te34 = (free_cnt > LIM_Q3);
    evt.full = is_full;
    evt.ovf  = push_req && is_full;
    evt.udr  = pop_req && is_empty;
    evt.done = is_empty && shifter_idle;
  end

endmodule

// File: rtl/txst_flag_bank.sv
module txst_flag_bank #(
  parameter int unsigned         DATA_W  = 32,
  parameter logic [DATA_W-1:0]   RST_VAL = '0,
  parameter logic [DATA_W-1:0]   IMPL    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] flags
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (IMPL[g]) begin : g_flag
      logic flag_q;
      logic flag_d;
      logic flag_en;

      always_comb begin
        flag_en = set_vec[g] | clr_vec[g];
        flag_d  = set_vec[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= RST_VAL[g];
        end else if (flag_en) begin
          flag_q <= flag_d;
        end
      end

      assign flags[g] = flag_q;
    end else begin : g_rsvd
      logic unused_bit;
      assign unused_bit = set_vec[g] ^ clr_vec[g];
      assign flags[g]   = 1'b0;
    end
  end

endmodule

// File: rtl/txst_irq_gen.sv
module txst_irq_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] mask,
  output logic              irq
);

  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(flags & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/tx_irq_status.sv
module tx_irq_status
  import txst_pkg::*;
#(
  parameter int unsigned          DEPTH      = 64,
  parameter int unsigned          LVL_W      = $clog2(DEPTH + 1),
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    REG_OFFSET = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              shifter_idle,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  logic              rst_sync_n;
  txst_evt_t         evt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] flags;
  logic              wr_hit;

  txst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  txst_cond_decode #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
    .fifo_level   (fifo_level),
    .push_req     (push_req),
    .pop_req      (pop_req),
    .shifter_idle (shifter_idle),
    .evt          (evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_DONE] = evt.done;
    set_vec[BIT_HALF] = evt.half;
    set_vec[BIT_FULL] = evt.full;
    set_vec[BIT_TE14] = evt.te14;
    set_vec[BIT_TE34] = evt.te34;
    set_vec[BIT_OVF]  = evt.ovf;
    set_vec[BIT_UDR]  = evt.udr;
  end

  always_comb begin
    wr_hit  = wr_en && (wr_addr == REG_OFFSET);
    clr_vec = wr_hit ? wr_data : '0;
  end

  txst_flag_bank #(
    .DATA_W  (STAT_W),
    .RST_VAL (STAT_RESET),
    .IMPL    (STAT_IMPL)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  txst_irq_gen #(.DATA_W(STAT_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flags (flags),
    .mask  (irq_mask),
    .irq   (irq)
  );

  assign status = flags;

endmodule

// File: rtl/tx_irq_status_chk.sv
module tx_irq_status_chk #(
  parameter int unsigned       DEPTH      = 64,
  parameter int unsigned       LVL_W      = 7,
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h10
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              push_req,
  input logic              pop_req,
  input logic              shifter_idle,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       irq_mask,
  input logic [31:0]       status,
  input logic              irq
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_Q1  = LVL_W'(DEPTH / 4);

  logic ovf_clr;
  assign ovf_clr = wr_en && (wr_addr == REG_OFFSET) && wr_data[13];

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_req && fifo_level == '0) |=> status[14]); // R2
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push_req && fifo_level == LVL_MAX) |=> status[13]); // R3
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_level == LVL_MAX) |=> status[10]); // R4
  AST_TE34_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_level < LVL_Q1) |=> status[12]); // R5
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_level == '0 && shifter_idle) |=> status[8]); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status[13] && !ovf_clr) |=> status[13]); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status[31:15] == '0) && (status[7:0] == '0)); // R9
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq == $past(|(status & irq_mask)))); // R10

endmodule

bind tx_irq_status tx_irq_status_chk #(
  .DEPTH      (DEPTH),
  .LVL_W      (LVL_W),
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .fifo_level   (fifo_level),
  .push_req     (push_req),
  .pop_req      (pop_req),
  .shifter_idle (shifter_idle),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .irq_mask     (irq_mask),
  .status       (status),
  .irq          (irq)
);

// File: tb/tx_irq_status_bench.sv
`timescale 1ns/1ps
module tx_irq_status_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  fifo_level;
  logic        push_req;
  logic        pop_req;
  logic        shifter_idle;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] irq_mask;
  logic [31:0] status;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  tx_irq_status u_tx_irq_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_level   (fifo_level),
    .push_req     (push_req),
    .pop_req      (pop_req),
    .shifter_idle (shifter_idle),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .irq_mask     (irq_mask),
    .status       (status),
    .irq          (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] addr, input logic [31:0] data);
    wr_en   = 1'b1;
    wr_addr = addr;
    wr_data = data;
    step();
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic clear_all();
    write_reg(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 32'h0000_1B00);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_level(input logic [6:0] lvl, input logic [31:0] exp, input string req);
    fifo_level = lvl;
    clear_all();
    check(req, status, exp);
    step();
    check(req, status, exp);
  endtask

  task automatic t_thresholds();
    t_level(7'd48, 32'h0000_0000, "R5 level 48 strict quarter");
    t_level(7'd47, 32'h0000_0800, "R5 level 47 quarter free");
    t_level(7'd32, 32'h0000_0800, "R5 level 32 strict half");
    t_level(7'd31, 32'h0000_0A00, "R5 level 31 half free");
    t_level(7'd16, 32'h0000_0A00, "R5 level 16 strict three quarter");
    t_level(7'd15, 32'h0000_1A00, "R5 level 15 three quarter free");
  endtask

  task automatic t_full_ovf();
    fifo_level = 7'd63;
    push_req   = 1'b1;
    clear_all();
    check("R3 push below full", status, 32'h0000_0000);
    fifo_level = 7'd64;
    clear_all();
    check("R3 R4 R8 overflow and full win over clear", status, 32'h0000_2400);
    push_req   = 1'b0;
    fifo_level = 7'd40;
    step();
    check("R7 sticky after condition ends", status, 32'h0000_2C00);
    write_reg(8'h10, 32'h0000_2000);
    check("R7 selective clear", status, 32'h0000_0C00);
    write_reg(8'h14, 32'hFFFF_FFFF);
    check("R7 other address ignored", status, 32'h0000_0C00);
  endtask

  task automatic t_udr_done();
    fifo_level   = 7'd1;
    pop_req      = 1'b1;
    shifter_idle = 1'b1;
    clear_all();
    check("R2 R6 pop at level 1", status, 32'h0000_1A00);
    fifo_level   = 7'd0;
    shifter_idle = 1'b0;
    clear_all();
    check("R2 R6 underrun with shifter busy", status, 32'h0000_5A00);
    pop_req      = 1'b0;
    shifter_idle = 1'b1;
    step();
    check("R6 R11 complete one edge after idle", status, 32'h0000_5B00);
    write_reg(8'h10, 32'hFFFF_FFFF);
    check("R9 reserved bits stay zero", status & 32'hFFFF_80FF, 32'h0);
    check("R9 level 0 idle status", status, 32'h0000_1B00);
    shifter_idle = 1'b0;
  endtask

  task automatic t_irq();
    fifo_level = 7'd40;
    clear_all();
    irq_mask = 32'h0000_2000;
    step();
    check("R10 irq low without overflow", {31'd0, irq}, 32'd0);
    fifo_level = 7'd64;
    push_req   = 1'b1;
    step();
    check("R10 irq not yet at flag edge", {31'd0, irq}, 32'd0);
    push_req   = 1'b0;
    fifo_level = 7'd40;
    step();
    check("R10 irq one edge after flag", {31'd0, irq}, 32'd1);
    irq_mask = 32'h0;
    step();
    check("R10 irq masked off", {31'd0, irq}, 32'd0);
    irq_mask = 32'h0000_2000;
    step();
    check("R10 irq unmasked again", {31'd0, irq}, 32'd1);
    write_reg(8'h10, 32'h0000_2000);
    check("R10 irq held for one edge after clear", {31'd0, irq}, 32'd1);
    check("R7 status after clear", status, 32'h0000_0C00);
    step();
    check("R10 irq drops after clear", {31'd0, irq}, 32'd0);
    irq_mask = 32'h0;
  endtask

  initial begin
    rst_n        = 1'b0;
    fifo_level   = '0;
    push_req     = 1'b0;
    pop_req      = 1'b0;
    shifter_idle = 1'b0;
    wr_en        = 1'b0;
    wr_addr      = '0;
    wr_data      = '0;
    irq_mask     = '0;
    @(negedge clk);
    t_reset();
    t_thresholds();
    t_full_ovf();
    t_udr_done();
    t_irq();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule